// File: doc/BRIEF.md
# Serial Memory Sync-Word Byte Reader

This block pulls user data out of a bit-serial configuration memory that holds other content ahead of it. It drives a serial clock to the memory and takes one data bit on each rising edge of that clock. It slides every incoming bit through a window that is 2^SYNC_LOG2 bits wide. When the window equals the synchronisation word on `pattern_i`, it emits a one-cycle active-low pulse on `found_n_o`.

After a match the block reads the next byte without waiting for a request. It then assembles each later byte only after `fetch_n_i` is pulsed low. Each finished byte is shown on `byte_o` and marked by a one-cycle active-low pulse on `byte_rdy_n_o`. While the block waits for a request the serial clock is parked low, so no bit is lost. A low pulse on `rehunt_n_i` starts a new search for a later copy of the word from the next unread bit. A high level on `restart_i` holds the memory in reset through the active-high `mem_rst_o` and then searches again from the memory's first bit.

The serial clock is the system clock divided by the smallest even ratio that keeps it at or below SCLK_MAX_MHZ. With the defaults (50 MHz system clock, 15 MHz ceiling) the ratio is 4, which gives 12.5 MHz.

Top module: `sersync_byte_reader`

## Requirements
- R1: While `rst_n` is low, `mem_rst_o` is 1, `ser_clk_o` is 0, and `found_n_o` and `byte_rdy_n_o` are both 1.
- R2: `ser_clk_o` has a period of 2*ceil(CLK_MHZ/(2*SCLK_MAX_MHZ)) system cycles, which is 4 cycles at the defaults. `ser_din_i` is sampled at the system edge where `ser_clk_o` rises. Bits are taken most-significant first.
- R3: `mem_rst_o` goes high on the edge after `restart_i` is seen high. It stays high while `restart_i` is high and for at least one serial clock period after the last cycle in which `restart_i` is high. The search then restarts from the memory's first bit. `restart_i` overrides every other input.
- R4: `found_n_o` is low for exactly one cycle once the last 2^SYNC_LOG2 bits sampled since the search began equal `pattern_i`. The earliest sampled of those bits is compared with the most significant bit of `pattern_i`.
- R5: The 8 bits that follow a match are assembled without any request. `byte_rdy_n_o` is then low for exactly one cycle, and `byte_o` carries the byte with its first-received bit in bit 7.
- R6: Each later byte is read only after a low pulse on `fetch_n_i` while the block waits. Pulses that arrive during a search or while a byte is being read are ignored and give no extra byte.
- R7: While the block waits for a request, `ser_clk_o` stays low and does not toggle, and `byte_o` keeps the last delivered byte.
- R8: A low pulse on `rehunt_n_i` while the block waits resumes the search at the next unread bit and needs 2^SYNC_LOG2 new bits before a match. If `rehunt_n_i` and `fetch_n_i` are both low, `rehunt_n_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Active-high request to reset the memory and search again |
| fetch_n_i | input | 1 | Active-low one-cycle request for the next byte |
| rehunt_n_i | input | 1 | Active-low one-cycle request to search for a later sync word |
| ser_din_i | input | 1 | Serial data from the memory |
| pattern_i | input | 2^SYNC_LOG2 | Synchronisation word to search for |
| ser_clk_o | output | 1 | Serial clock to the memory |
| mem_rst_o | output | 1 | Active-high reset to the memory's output-enable pin |
| found_n_o | output | 1 | Active-low one-cycle pulse when the sync word is matched |
| byte_rdy_n_o | output | 1 | Active-low one-cycle pulse when `byte_o` holds a new byte |
| byte_o | output | 8 | Last assembled byte |

## Verification
The assertions assume that `fetch_n_i` and `rehunt_n_i` are single-cycle low pulses, that `pattern_i` changes only while a restart is in progress, and that the memory changes `ser_din_i` only after a falling edge of `ser_clk_o`. The bench respects these conditions. It drives every input at the falling system edge. It models the memory as a bit array whose read pointer moves forward on each falling serial edge and returns to zero while `mem_rst_o` is high. It changes the pattern only just before it pulses `restart_i`. The random parts are the prefix length, the gaps, the data bytes and the delays between requests. Directed cases add requests during a search and during a read, and a simultaneous search and fetch request.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [2:0] {
    S_MEMRST = 3'd0,
    S_HUNT   = 3'd1,
    S_FOUND  = 3'd2,
    S_READ   = 3'd3,
    S_DELIV  = 3'd4,
    S_WAIT   = 3'd5
  } rd_state_e;

endpackage

// File: rtl/srd_sclk_div.sv
module srd_sclk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic sclk_o,
  output logic sample_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          active, wrap;

  // keep running until a high phase has ended, so the clock parks low
  assign active = run_i | sclk_q;
  assign wrap   = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (clr_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (active) begin
      if (wrap) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign sample_o = run_i & ~clr_i & ~sclk_q & wrap;

  // R2: a sample strobe coincides with a rising serial edge
  a_r2_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> $rose(sclk_q));

  // R7: with no run request a parked clock stays low
  a_r7_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sclk_q) |=> !sclk_q);

endmodule

// File: rtl/srd_hunter.sv
module srd_hunter #(
  parameter int SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [SYNC_W-1:0] pattern_i,
  output logic              match_o
);
  localparam int FW = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] win_q, win_d;
  logic [FW-1:0]     fill_q, fill_d;
  logic              full;

  assign full = (fill_q == FW'(SYNC_W));

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (clr_i) begin
      win_d  = '0;
      fill_d = '0;
    end else if (shift_i) begin
      win_d = {win_q[SYNC_W-2:0], bit_i};
      if (!full) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  assign match_o = full & (win_q == pattern_i);

  // R8: after a clear no match is possible on the next cycle
  a_r8_clear_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !match_o);

endmodule

// File: rtl/srd_byte_asm.sv
module srd_byte_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       shift_i,
  input  logic       bit_i,
  output logic       done_o,
  output logic [7:0] byte_o
);
  logic [6:0] sh_q, sh_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] byte_q, byte_d;

  assign done_o = shift_i & (cnt_q == 3'd7);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[5:0], bit_i};
      cnt_d = cnt_q + 1'b1;
    end
    if (done_o) byte_d = {sh_q, bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign byte_o = byte_q;

  // R7: the output byte only changes after a completed byte
  a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_q) |-> $past(done_o));

endmodule

// File: rtl/srd_ctrl.sv
module srd_ctrl
  import srd_pkg::*;
#(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic fetch_n_i,
  input  logic rehunt_n_i,
  input  logic match_i,
  input  logic byte_done_i,
  output logic mem_rst_o,
  output logic hunt_o,
  output logic read_o,
  output logic found_n_o,
  output logic rdy_n_o
);
  localparam int RW = $clog2(PERIOD + 1);

  rd_state_e     st_q, st_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    st_d   = st_q;
    rcnt_d = '0;
    unique case (st_q)
      S_MEMRST: begin
        if (rcnt_q == RW'(PERIOD - 1)) st_d = S_HUNT;
        else rcnt_d = rcnt_q + 1'b1;
      end
      S_HUNT:  if (match_i) st_d = S_FOUND;
      S_FOUND: st_d = S_READ;
      S_READ:  if (byte_done_i) st_d = S_DELIV;
      S_DELIV: st_d = S_WAIT;
      S_WAIT: begin
        if (!rehunt_n_i)     st_d = S_HUNT;
        else if (!fetch_n_i) st_d = S_READ;
      end
      default: st_d = S_MEMRST;
    endcase
    if (restart_i) begin
      st_d   = S_MEMRST;
      rcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_MEMRST;
      rcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign mem_rst_o = (st_q == S_MEMRST);
  assign hunt_o    = (st_q == S_HUNT);
  assign read_o    = (st_q == S_READ);
  assign found_n_o = ~(st_q == S_FOUND);
  assign rdy_n_o   = ~(st_q == S_DELIV);

  // R3: a restart request always leads to memory reset
  a_r3_hold_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> mem_rst_o);

  // R4: sync pulse is one cycle wide
  a_r4_found_single: assert property (@(posedge clk) disable iff (!rst_n)
    !found_n_o |=> found_n_o);

  // R5: byte-ready pulse is one cycle wide
  a_r5_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_o |=> rdy_n_o);

  // R8: a search request while waiting wins over a fetch request
  a_r8_rehunt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !rehunt_n_i && !restart_i) |=> hunt_o);

endmodule

// File: rtl/sersync_byte_reader.sv
module sersync_byte_reader #(
  parameter int SYNC_LOG2    = 5,
  parameter int CLK_MHZ      = 50,
  parameter int SCLK_MAX_MHZ = 15,
  localparam int SYNC_W      = 1 << SYNC_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              fetch_n_i,
  input  logic              rehunt_n_i,
  input  logic              ser_din_i,
  input  logic [SYNC_W-1:0] pattern_i,
  output logic              ser_clk_o,
  output logic              mem_rst_o,
  output logic              found_n_o,
  output logic              byte_rdy_n_o,
  output logic [7:0]        byte_o
);
  localparam int HALF_RAW = (CLK_MHZ + 2 * SCLK_MAX_MHZ - 1) / (2 * SCLK_MAX_MHZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int PERIOD   = 2 * HALF;

  logic sample, hunting, reading, match, byte_done;

  srd_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_i),
    .fetch_n_i  (fetch_n_i),
    .rehunt_n_i (rehunt_n_i),
    .match_i    (match),
    .byte_done_i(byte_done),
    .mem_rst_o  (mem_rst_o),
    .hunt_o     (hunting),
    .read_o     (reading),
    .found_n_o  (found_n_o),
    .rdy_n_o    (byte_rdy_n_o)
  );

  srd_sclk_div #(.HALF(HALF)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (mem_rst_o),
    .run_i   (hunting | reading),
    .sclk_o  (ser_clk_o),
    .sample_o(sample)
  );

  srd_hunter #(.SYNC_W(SYNC_W)) hunt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (~hunting),
    .shift_i  (sample & hunting),
    .bit_i    (ser_din_i),
    .pattern_i(pattern_i),
    .match_o  (match)
  );

  srd_byte_asm asm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (~reading),
    .shift_i(sample & reading),
    .bit_i  (ser_din_i),
    .done_o (byte_done),
    .byte_o (byte_o)
  );

endmodule

// File: tb/sersync_byte_reader_tb_top.sv
`timescale 1ns/1ps
module sersync_byte_reader_tb_top;
  localparam int SW     = 32;
  localparam int PERIOD = 4;
  localparam int NBITS  = 1024;
  localparam logic [31:0] PAT_A = 32'hC3A5_5A1E;
  localparam logic [31:0] PAT_B = 32'h6D2B_F0E4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, restart, fetch_n, rehunt_n, din;
  logic [31:0] pattern;
  logic ser_clk, mem_rst, found_n, rdy_n;
  logic [7:0] byte_out;

  sersync_byte_reader dut_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .fetch_n_i(fetch_n),
    .rehunt_n_i(rehunt_n), .ser_din_i(din), .pattern_i(pattern),
    .ser_clk_o(ser_clk), .mem_rst_o(mem_rst), .found_n_o(found_n),
    .byte_rdy_n_o(rdy_n), .byte_o(byte_out)
  );

  bit stream [0:NBITS-1];
  int ptr = 0;
  logic sclk_prev = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  // memory model: advance on falling serial edge, rewind while in reset
  always @(negedge clk) begin
    if (mem_rst) ptr <= 0;
    else if (sclk_prev && !ser_clk) ptr <= ptr + 1;
    sclk_prev <= ser_clk;
  end
  assign din = (ptr < NBITS) ? stream[ptr] : 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(inout int pos, input logic [31:0] v, input int n);
    for (int j = n - 1; j >= 0; j--) begin
      stream[pos] = v[j];
      pos++;
    end
  endtask

  function automatic int find_sync(input int start, input logic [31:0] pat);
    for (int e = start + SW - 1; e < NBITS; e++) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < SW; j++) w = {w[30:0], stream[e - SW + 1 + j]};
      if (w == pat) return e + 1;
    end
    return -1;
  endfunction

  function automatic logic [7:0] get_byte(input int pos);
    logic [7:0] b;
    b = '0;
    for (int j = 0; j < 8; j++) b = {b[6:0], stream[pos + j]};
    return b;
  endfunction

  task automatic pulse_fetch();
    @(negedge clk) fetch_n = 1'b0;
    @(negedge clk) fetch_n = 1'b1;
  endtask

  task automatic wait_found(output bit got, output int rdy_seen);
    got = 0;
    rdy_seen = 0;
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (!rdy_n) rdy_seen++;
      if (!found_n) got = 1;
    end
    check(got, "R4", "sync pulse seen", got, 1);
    if (got) begin
      @(negedge clk);
      check(found_n == 1'b1, "R4", "sync pulse width", found_n, 1);
    end
  endtask

  task automatic wait_byte(input string req, input logic [7:0] exp);
    bit got;
    logic [7:0] b;
    got = 0;
    b = '0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (!rdy_n) begin
        got = 1;
        b = byte_out;
      end
    end
    check(got && b == exp, req, "byte value", b, exp);
    if (got) begin
      @(negedge clk);
      check(rdy_n == 1'b1, "R5", "ready pulse width", rdy_n, 1);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pos, m, m2, m3, rs, c;
    bit got;
    logic [7:0] held;
    void'($urandom(32'd20240611));

    for (int i = 0; i < NBITS; i++) stream[i] = bit'($urandom % 2);
    pos = 40 + int'($urandom % 30);
    put(pos, PAT_A, 32);
    for (int i = 0; i < 6; i++) put(pos, $urandom, 8);
    pos += 16 + int'($urandom % 24);
    put(pos, PAT_A, 32);
    for (int i = 0; i < 4; i++) put(pos, $urandom, 8);
    pos += 10 + int'($urandom % 20);
    put(pos, PAT_B, 32);
    for (int i = 0; i < 4; i++) put(pos, $urandom, 8);

    rst_n = 1'b0; restart = 1'b0; fetch_n = 1'b1; rehunt_n = 1'b1;
    pattern = PAT_A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_rst == 1'b1, "R1", "mem reset during reset", mem_rst, 1);
    check(ser_clk == 1'b0, "R1", "serial clock low", ser_clk, 0);
    check(found_n == 1'b1, "R1", "sync pulse idle", found_n, 1);
    check(rdy_n == 1'b1, "R1", "ready pulse idle", rdy_n, 1);
    rst_n = 1'b1;

    // R2 serial clock period, measured while searching
    begin
      logic pv;
      int n;
      pv = ser_clk;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (ser_clk && !pv) break;
        pv = ser_clk;
      end
      n = 0;
      pv = ser_clk;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        n++;
        if (ser_clk && !pv) break;
        pv = ser_clk;
      end
      check(n == PERIOD, "R2", "serial clock period", n, PERIOD);
    end

    // R6 request during search is ignored
    pulse_fetch();

    m = find_sync(0, PAT_A);
    wait_found(got, rs);
    check(rs == 0, "R6", "no byte during search", rs, 0);
    wait_byte("R5", get_byte(m));

    // R7 idle: clock parked low and byte held
    repeat (2 * PERIOD) @(negedge clk);
    held = byte_out;
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ser_clk || byte_out != held || !rdy_n) c++;
    end
    check(c == 0, "R7", "idle cycles with activity", c, 0);

    for (int k = 1; k <= 5; k++) begin
      repeat (int'($urandom % 20)) @(negedge clk);
      pulse_fetch();
      if (k == 3) begin
        repeat (2) @(negedge clk);
        pulse_fetch();
      end
      wait_byte("R6", get_byte(m + 8 * k));
      if (k == 3) begin
        c = 0;
        for (int i = 0; i < 80; i++) begin
          @(negedge clk);
          if (!rdy_n) c++;
        end
        check(c == 0, "R6", "extra bytes from request during read", c, 0);
      end
    end

    // R8 search again, with a fetch request in the same cycle
    m2 = find_sync(m + 48, PAT_A);
    @(negedge clk) begin rehunt_n = 1'b0; fetch_n = 1'b0; end
    @(negedge clk) begin rehunt_n = 1'b1; fetch_n = 1'b1; end
    wait_found(got, rs);
    check(rs == 0, "R8", "search wins over fetch", rs, 0);
    wait_byte("R8", get_byte(m2));
    for (int k = 1; k <= 2; k++) begin
      repeat (int'($urandom % 10)) @(negedge clk);
      pulse_fetch();
      wait_byte("R6", get_byte(m2 + 8 * k));
    end

    // R3 restart with a new pattern
    @(negedge clk) pattern = PAT_B;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    c = 0;
    while (mem_rst && c < 100) begin
      c++;
      @(negedge clk);
    end
    check(c >= PERIOD && c < 100, "R3", "memory reset cycles", c, PERIOD);
    m3 = find_sync(0, PAT_B);
    wait_found(got, rs);
    wait_byte("R3", get_byte(m3));
    pulse_fetch();
    wait_byte("R6", get_byte(m3 + 8));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule